// File: doc/BRIEF.md
# Configurable Serial Byte Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. A frame is a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. The width of every bit, counted in system clocks, is set by a divisor value D: each bit lasts D+1 clocks, so the line rate is the clock frequency divided by D+1.

There is no transmit buffer. The block raises `ready` while idle. A byte is taken only when the write strobe is high while `ready` is high. The divisor, parity mode, stop-bit select and trigger enable are captured with the byte, so changing them mid-frame does not disturb the frame in flight. When the trigger enable was set at acceptance, a one-clock `trig` pulse marks the end of the last stop bit. This suits a host that polls `ready` before each write.

Top module: `ser_tx`

## Requirements
- R1: After reset, and at all times while `ready` is 1, `tx` is 1 and `trig` is 0 except for the end-of-frame pulse of R9.
- R2: When `wr_en` is 1 at a rising edge while `ready` is 1, the byte is accepted. From the next cycle `ready` is 0 and `tx` carries the low start bit. `divisor`, `parity_sel`, `two_stop` and `trig_en` are captured at that edge and govern the whole frame.
- R3: Every bit of the frame, start, data, parity and stop, holds `tx` steady for exactly D+1 clock cycles, where D is the captured divisor.
- R4: After the start bit the eight data bits follow, bit 0 first and bit 7 last.
- R5: `parity_sel` code 0 sends no parity bit. Code 1 (odd) sends a parity bit that makes the count of ones over data and parity odd. Code 2 (even) makes that count even. The parity bit follows data bit 7. Code 3 is treated as code 0.
- R6: `two_stop` = 0 ends the frame with one high stop bit. `two_stop` = 1 ends it with two.
- R7: `ready` stays 0 for exactly N*(D+1) cycles after acceptance, where N = 10 + (parity on) + `two_stop`, and then returns to 1.
- R8: A write while `ready` is 0 is ignored: it changes neither the frame in flight nor starts a new frame afterwards.
- R9: If `trig_en` was 1 at acceptance, `trig` is 1 for exactly one cycle: the first cycle in which `ready` is 1 again. With `trig_en` 0, no pulse occurs.
- R10: The minimum divisor D = 1 is supported and gives two-clock bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the byte on `wr_data` |
| wr_data | input | 8 | Byte to send |
| divisor | input | DIV_W (16) | Bit period minus one, in clocks; minimum 1 |
| parity_sel | input | 2 | 0 none, 1 odd, 2 even, 3 treated as none |
| two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| trig_en | input | 1 | Enables the end-of-frame pulse |
| tx | output | 1 | Serial line, idles high |
| ready | output | 1 | 1 when a new byte can be accepted |
| trig | output | 1 | One-cycle end-of-frame pulse |

## Verification
A bit-period counter that wraps at the wrong count first shows as a start bit that is too long or too short, so the error appears within the first D+2 cycles of a frame. A shift register or parity error shows on `tx` in the data or parity bit period itself. A wrong remaining-bit count shows as `ready` and `trig` moving one bit period off at the end of the frame. The bench samples `tx`, `ready` and `trig` on every cycle of every frame, over all parity and stop settings, small divisors and every byte value.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2,
    PAR_RSVD = 2'd3
  } par_mode_e;

  function automatic logic parity_on(input par_mode_e m);
    return (m == PAR_ODD) || (m == PAR_EVEN);
  endfunction

endpackage

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             bit_end
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= {{(DIV_W-1){1'b0}}, 1'b1};
      cnt_q <= '0;
    end else if (load) begin
      div_q <= div_in;
      cnt_q <= '0;
    end else if (run) begin
      if (cnt_q == div_q) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_end = run && (cnt_q == div_q);

  assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= div_q);

endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  par_mode_e         par_mode,
  input  logic              two_stop,
  input  logic              bit_end,
  output logic              tx,
  output logic              busy,
  output logic              last_bit
);

  localparam int SH_W  = DATA_W + 3;
  localparam int MAX_N = DATA_W + 4;
  localparam int CNT_W = $clog2(MAX_N + 1);

  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] left_q;
  logic [SH_W-1:0]  load_vec;
  logic [CNT_W-1:0] load_cnt;
  logic             pbit;
  logic             pon;

  always_comb begin
    pon  = parity_on(par_mode);
    pbit = (^data) ^ (par_mode == PAR_ODD);
    if (pon) load_vec = {2'b11, pbit, data};
    else     load_vec = {3'b111, data};
    load_cnt = CNT_W'(1 + DATA_W + 1) + CNT_W'(pon) + CNT_W'(two_stop);
  end

  assign last_bit = bit_end && (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      left_q <= '0;
      busy   <= 1'b0;
      tx     <= 1'b1;
    end else if (load) begin
      sh_q   <= load_vec;
      left_q <= load_cnt;
      busy   <= 1'b1;
      tx     <= 1'b0;
    end else if (bit_end) begin
      if (left_q == CNT_W'(1)) begin
        busy   <= 1'b0;
        left_q <= '0;
        tx     <= 1'b1;
      end else begin
        tx     <= sh_q[0];
        sh_q   <= {1'b1, sh_q[SH_W-1:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx);

  assert_count_live_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (left_q != '0) && (left_q <= CNT_W'(MAX_N)));

endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import ser_tx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        parity_sel,
  input  logic              two_stop,
  input  logic              trig_en,
  output logic              tx,
  output logic              ready,
  output logic              trig
);

  logic accept;
  logic busy;
  logic bit_end;
  logic last_bit;
  logic trig_en_q;

  assign ready  = !busy;
  assign accept = wr_en && ready;

  ser_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .div_in  (divisor),
    .run     (busy),
    .bit_end (bit_end)
  );

  ser_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .data     (wr_data),
    .par_mode (par_mode_e'(parity_sel)),
    .two_stop (two_stop),
    .bit_end  (bit_end),
    .tx       (tx),
    .busy     (busy),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_en_q <= 1'b0;
      trig      <= 1'b0;
    end else begin
      if (accept) trig_en_q <= trig_en;
      trig <= last_bit && trig_en_q;
    end
  end

  assert_start_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!ready && !tx));

  assert_trig_single_R9: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);

  assert_trig_on_ready_rise_R9: assert property (@(posedge clk) disable iff (rst)
    trig |-> (ready && $past(!ready)));

  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ready && !last_bit) |=> !ready);

endmodule

// File: tb/ser_tx_bench.sv
module ser_tx_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [15:0] divisor = 16'd1;
  logic [1:0] parity_sel = '0;
  logic       two_stop = 1'b0;
  logic       trig_en = 1'b0;
  logic       tx, ready, trig;

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  ser_tx u_ser_tx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .divisor(divisor), .parity_sel(parity_sel), .two_stop(two_stop),
    .trig_en(trig_en), .tx(tx), .ready(ready), .trig(trig)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int j, input logic [7:0] d, input int par);
    if (j == 0) return 1'b0;
    if (j <= 8) return d[j-1];
    if (j == 9 && (par == 1 || par == 2))
      return (^d) ^ (par == 1);
    return 1'b1;
  endfunction

  // Sends one byte and checks every cycle of the frame plus three after it.
  task automatic send(input logic [7:0] d, input int dv, input int par,
                      input bit st, input bit en, input bit inj);
    int per, nb, tot, tx_bad, rdy_bad, trg_bad;
    per = dv + 1;
    nb  = 10 + ((par == 1 || par == 2) ? 1 : 0) + (st ? 1 : 0);
    tot = nb * per;
    tx_bad = 0; rdy_bad = 0; trg_bad = 0;
    @(negedge clk);
    wr_data = d; divisor = 16'(dv); parity_sel = 2'(par);
    two_stop = st; trig_en = en; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    for (int m = 0; m <= tot + 2; m++) begin
      if (tx !== exp_bit(m / per, d, par)) tx_bad++;
      if (ready !== (m >= tot)) rdy_bad++;
      if (trig !== (en && m == tot)) trg_bad++;
      if (inj && m == 2) begin
        wr_en = 1'b1; wr_data = ~d; divisor = 16'(dv + 1);
        parity_sel = 2'((par + 1) % 4); two_stop = ~st; trig_en = ~en;
      end
      if (inj && m == 3) wr_en = 1'b0;
      @(negedge clk);
    end
    check(tx_bad == 0, inj ? "R8 tx frame with busy write" : "R3/R4/R5/R6 tx frame",
          tx_bad, 0);
    check(rdy_bad == 0, "R7 ready window", rdy_bad, 0);
    check(trg_bad == 0, "R9 trig pulse", trg_bad, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx === 1'b1, "R1 reset tx", int'(tx), 1);
    check(ready === 1'b1, "R1 reset ready", int'(ready), 1);
    check(trig === 1'b0, "R1 reset trig", int'(trig), 0);

    // R2 R3 R5 R6 R9 sweep over small divisors, all parity codes, both stop settings
    for (int dv = 1; dv <= 3; dv++)
      for (int par = 0; par < 4; par++)
        for (int st = 0; st < 2; st++) begin
          send(8'h00, dv, par, st[0], 1'b1, 1'b0);
          send(8'hFF, dv, par, st[0], 1'b0, 1'b0);
          send(8'hA5, dv, par, st[0], 1'b1, 1'b1);
          send(8'h01, dv, par, st[0], 1'b0, 1'b0);
          send(8'h80, dv, par, st[0], 1'b1, 1'b1);
          send(8'(dv * 37 + par * 11 + st), dv, par, st[0], st[0], 1'b0);
        end

    // R4 R10 every byte at the minimum divisor, odd and even parity alternating
    for (int b = 0; b < 256; b++)
      send(8'(b), 1, (b % 2) + 1, b[2], b[1], b[3]);

    // R2 a larger divisor to exercise a longer bit period
    send(8'h3C, 9, 2, 1'b1, 1'b1, 1'b1);

    // R8 R1 idle line stays high with no frame after an ignored write
    repeat (5) @(negedge clk);
    check(tx === 1'b1 && ready === 1'b1, "R8 idle after frames", int'({tx, ready}), 3);

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule